// File: doc/BRIEF.md
# I2C Transmit Data Buffer

This block is the transmit data path of an I2C-style serial port. Software writes a byte into a holding register. When the bus is owned and the shifter is free, the byte moves into a shift register. The shift register places the byte on SDA, most significant bit first, and then releases the line for the acknowledge clock. A read-only write-request flag tells software when the holding register may take the next byte.

The block does not generate the clock and does not detect bus conditions. A bus front end supplies one-cycle strobes for start detect, stop detect, SCL rising edge and SCL falling edge, plus the sampled SDA level. Two controls come from configuration: an interface enable and an acknowledge-check enable. A one-cycle initialize pulse and a transmit-mode bit complete the inputs. Two cases make the flag fall and rise again. A byte written after the last transfer has finished moves into the shifter one cycle later. A byte written while the shifter is idle and the bus is owned does the same. When acknowledge checking is on, a NACK leaves the flag clear and holds back the waiting byte.

Top module: `i2c_tx_buffer`

## Requirements
- R1: After reset, wreq_o is 0, sda_o is 1 (released) and ack_o is 0.
- R2: A start detect sets wreq_o in the next cycle, unless a stop, a disable, an initialize or an accepted write comes in the same cycle. The same rule applies with en_i at 1 and init_i at 0.
- R3: An accepted write (wr_i with tx_mode_i at 1) clears wreq_o in the next cycle. If the bus is owned and the shifter is idle, the byte moves into the shifter on the following cycle and wreq_o returns to 1.
- R4: If a byte is waiting when the current byte ends, it moves into the shifter on the 9th SCL rising edge, and wreq_o becomes 1 in that cycle.
- R5: The shifter presents the first data bit after the first SCL falling edge that follows the load. It advances one bit, MSB first, on each later falling edge, for DATA_W bits. It releases SDA (sda_o = 1) on the falling edge after the last data rising edge. The pulse counter never exceeds DATA_W.
- R6: On the 9th SCL rising edge of an active byte, ack_o takes the sampled SDA level (0 = ACK, 1 = NACK).
- R7: With ack_chk_i at 1, a NACK at the 9th rising edge leaves wreq_o unchanged and blocks any transfer into the shifter. The block stays this way until the next start, stop or initialize, and SDA stays released.
- R8: A stop detect clears wreq_o, ends the active byte (sda_o = 1) and releases bus ownership, so no byte is loaded until the next start.
- R9: A cycle with en_i at 0 or with init_i at 1 clears wreq_o, the holding register's valid bit, the pulse counter and the shifter. While en_i is 0, start detects do not set wreq_o.
- R10: A write with tx_mode_i at 0 is ignored: wreq_o does not change, and the byte is never sent.
- R11: When a byte ends with nothing waiting, wreq_o stays 1 and the shifter goes idle. With ack_chk_i at 0, a NACK is treated like an ACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Interface enable; 0 holds the block cleared |
| init_i | input | 1 | One-cycle internal initialize |
| tx_mode_i | input | 1 | Transmit mode; writes and loads only when 1 |
| ack_chk_i | input | 1 | Enables the acknowledge decision |
| wr_i | input | 1 | Software write strobe for the holding register |
| wdata_i | input | DATA_W | Write data |
| start_det_i | input | 1 | Start condition detected (one cycle) |
| stop_det_i | input | 1 | Stop condition detected (one cycle) |
| scl_rise_i | input | 1 | SCL rising edge strobe |
| scl_fall_i | input | 1 | SCL falling edge strobe |
| sda_i | input | 1 | Sampled SDA level |
| sda_o | output | 1 | SDA drive value, 1 = released |
| wreq_o | output | 1 | Write-request flag |
| ack_o | output | 1 | Last sampled acknowledge bit |

## Verification
The bench builds the block with the default DATA_W of 8. Each byte therefore takes nine SCL pulses, and the bench can compare every bit position and the release in the acknowledge slot against explicit byte patterns in a few hundred cycles. The width keeps the drop-and-rise write, the load on the 9th edge and the checked NACK close together in one run. They can then be followed by a stop, a restart and an initialize while a byte is pending.

// File: rtl/i2c_txb_pkg.sv
package i2c_txb_pkg;
  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } bus_ev_t;

  function automatic int unsigned cnt_width(input int unsigned data_w);
    return $clog2(data_w + 2);
  endfunction
endpackage

// File: rtl/i2c_txb_hold.sv
module i2c_txb_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              take_i,
  output logic [DATA_W-1:0] data_o,
  output logic              vld_o
);
  logic [DATA_W-1:0] data_q;
  logic              vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else if (clr_i) begin
      vld_q <= 1'b0;
    end else begin
      if (take_i) vld_q <= 1'b0;
      // a write in the take cycle refills the register
      if (wr_i) begin
        data_q <= wdata_i;
        vld_q  <= 1'b1;
      end
    end
  end

  assign data_o = data_q;
  assign vld_o  = vld_q;
endmodule

// File: rtl/i2c_txb_shifter.sv
module i2c_txb_shifter #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  load_i,
  input  logic [DATA_W-1:0]     ldata_i,
  input  i2c_txb_pkg::bus_ev_t  ev_i,
  output logic                  act_o,
  output logic                  done_o,
  output logic [CNT_W-1:0]      cnt_o,
  output logic                  sda_o
);
  localparam logic [CNT_W-1:0] LastCnt = CNT_W'(DATA_W);

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              act_q;
  logic              drv_q;
  logic              ack_slot;

  assign ack_slot = (cnt_q == LastCnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
      drv_q <= 1'b0;
    end else if (load_i) begin
      sh_q  <= ldata_i;
      cnt_q <= '0;
      act_q <= 1'b1;
      drv_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      act_q <= 1'b0;
      drv_q <= 1'b0;
    end else if (act_q) begin
      if (ev_i.rise) begin
        if (ack_slot) begin
          act_q <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (ev_i.fall) begin
        if (ack_slot)   drv_q <= 1'b0;               // release for acknowledge
        else if (drv_q) sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
        else            drv_q <= 1'b1;               // first bit goes out
      end
    end
  end

  assign done_o = act_q & ev_i.rise & ack_slot & ~clr_i;
  assign act_o  = act_q;
  assign cnt_o  = cnt_q;
  assign sda_o  = (act_q & drv_q) ? sh_q[DATA_W-1] : 1'b1;
endmodule

// File: rtl/i2c_txb_flag.sv
module i2c_txb_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic wr_i,
  input  logic set_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (clr_i) flag_q <= 1'b0;
    else if (wr_i)  flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/i2c_tx_buffer.sv
module i2c_tx_buffer #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              init_i,
  input  logic              tx_mode_i,
  input  logic              ack_chk_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              start_det_i,
  input  logic              stop_det_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              wreq_o,
  output logic              ack_o
);
  import i2c_txb_pkg::*;

  localparam int unsigned CNT_W = cnt_width(DATA_W);

  bus_ev_t           ev;
  logic              kill, wr_ok, sh_clr;
  logic              done, nack_end, bus_ok, blocked, free, load;
  logic              bus_q, nack_q, ack_q;
  logic              act;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] hold_data;
  logic              hold_vld;

  assign ev = '{start: start_det_i, stop: stop_det_i, rise: scl_rise_i, fall: scl_fall_i};

  assign kill     = ~en_i | init_i;
  assign wr_ok    = wr_i & tx_mode_i & ~kill;
  assign sh_clr   = kill | start_det_i | stop_det_i;
  assign nack_end = done & ack_chk_i & sda_i;
  assign bus_ok   = (bus_q | start_det_i) & ~stop_det_i & ~kill;
  assign blocked  = nack_q & ~start_det_i;
  assign free     = ~act | done | start_det_i;
  assign load     = hold_vld & tx_mode_i & bus_ok & ~blocked & free & ~nack_end;

  i2c_txb_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (kill),
    .wr_i    (wr_ok),
    .wdata_i (wdata_i),
    .take_i  (load),
    .data_o  (hold_data),
    .vld_o   (hold_vld)
  );

  i2c_txb_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (sh_clr),
    .load_i  (load),
    .ldata_i (hold_data),
    .ev_i    (ev),
    .act_o   (act),
    .done_o  (done),
    .cnt_o   (cnt),
    .sda_o   (sda_o)
  );

  i2c_txb_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (kill | stop_det_i),
    .wr_i   (wr_ok),
    .set_i  (load | start_det_i),
    .flag_o (wreq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_q  <= 1'b0;
      nack_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      if (kill || stop_det_i) bus_q <= 1'b0;
      else if (start_det_i)   bus_q <= 1'b1;

      if (sh_clr)        nack_q <= 1'b0;
      else if (nack_end) nack_q <= 1'b1;

      if (done) ack_q <= sda_i;
    end
  end

  assign ack_o = ack_q;
endmodule

// File: rtl/i2c_tx_buffer_chk.sv
module i2c_tx_buffer_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             init_i,
  input logic             tx_mode_i,
  input logic             ack_chk_i,
  input logic             wr_i,
  input logic             start_det_i,
  input logic             stop_det_i,
  input logic             scl_rise_i,
  input logic             scl_fall_i,
  input logic             sda_i,
  input logic             sda_o,
  input logic             wreq_o,
  input logic             act,
  input logic [CNT_W-1:0] cnt,
  input logic             hold_vld
);
  localparam logic [CNT_W-1:0] LastCnt = CNT_W'(DATA_W);

  p_start_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_det_i && en_i && !init_i && !stop_det_i && !(wr_i && tx_mode_i)) |=> wreq_o);

  p_write_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && tx_mode_i) |=> !wreq_o);

  p_ack_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && cnt == LastCnt && scl_fall_i) |=> sda_o);

  p_cnt_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= LastCnt);

  p_nack_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && cnt == LastCnt && scl_rise_i && ack_chk_i && sda_i && !wreq_o &&
     en_i && !init_i && !start_det_i && !stop_det_i && !(wr_i && tx_mode_i)) |=> !wreq_o);

  p_stop_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det_i |=> !wreq_o);

  p_kill_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || init_i) |=> (!wreq_o && !hold_vld && cnt == '0));

  p_tx_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !tx_mode_i && en_i && !init_i && !start_det_i && !stop_det_i) |=> $stable(wreq_o));
endmodule

bind i2c_tx_buffer i2c_tx_buffer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .init_i      (init_i),
  .tx_mode_i   (tx_mode_i),
  .ack_chk_i   (ack_chk_i),
  .wr_i        (wr_i),
  .start_det_i (start_det_i),
  .stop_det_i  (stop_det_i),
  .scl_rise_i  (scl_rise_i),
  .scl_fall_i  (scl_fall_i),
  .sda_i       (sda_i),
  .sda_o       (sda_o),
  .wreq_o      (wreq_o),
  .act         (act),
  .cnt         (cnt),
  .hold_vld    (hold_vld)
);

// File: tb/tb_i2c_tx_buffer.sv
module tb_i2c_tx_buffer;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, init = 1'b0, tx = 1'b0, chk = 1'b0, wr = 1'b0;
  logic [DW-1:0] wd = '0;
  logic start = 1'b0, stop = 1'b0, rise = 1'b0, fall = 1'b0, sda_in = 1'b0;
  logic sda_o, wreq_o, ack_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string tag = "R1";
  bit done_run = 1'b0;

  always #4 clk = ~clk;

  i2c_tx_buffer #(.DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .init_i(init), .tx_mode_i(tx),
    .ack_chk_i(chk), .wr_i(wr), .wdata_i(wd), .start_det_i(start),
    .stop_det_i(stop), .scl_rise_i(rise), .scl_fall_i(fall), .sda_i(sda_in),
    .sda_o(sda_o), .wreq_o(wreq_o), .ack_o(ack_o)
  );

  // behavioural reference model
  bit m_flag, m_hv, m_act, m_drv, m_bus, m_nack, m_ack;
  int m_cnt, m_pos, m_hold, m_byte;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag = 0; m_hv = 0; m_act = 0; m_drv = 0; m_bus = 0; m_nack = 0; m_ack = 0;
      m_cnt = 0; m_pos = 7; m_hold = 0; m_byte = 0;
    end else begin
      bit kill, wrok, fin, nend, busok, ld;
      kill  = !en || init;
      wrok  = wr && tx && !kill;
      fin   = m_act && rise && m_cnt == DW && !kill && !start && !stop;
      nend  = fin && chk && sda_in;
      busok = (m_bus || start) && !stop && !kill;
      ld    = m_hv && tx && busok && !(m_nack && !start) && (!m_act || fin || start) && !nend;
      if (ld) begin
        m_byte = m_hold; m_act = 1; m_cnt = 0; m_drv = 0; m_pos = DW - 1;
      end else if (kill || start || stop) begin
        m_act = 0; m_cnt = 0; m_drv = 0;
      end else if (m_act) begin
        if (rise) begin
          if (m_cnt == DW) begin m_act = 0; m_cnt = 0; end
          else m_cnt++;
        end else if (fall) begin
          if (m_cnt == DW) m_drv = 0;
          else if (m_drv) m_pos--;
          else m_drv = 1;
        end
      end
      if (kill) m_hv = 0;
      else begin
        if (ld) m_hv = 0;
        if (wrok) begin m_hold = int'(wd); m_hv = 1; end
      end
      if (kill || stop) m_flag = 0;
      else if (wrok) m_flag = 0;
      else if (ld || start) m_flag = 1;
      if (kill || stop) m_bus = 0; else if (start) m_bus = 1;
      if (kill || start || stop) m_nack = 0; else if (nend) m_nack = 1;
      if (fin) m_ack = sda_in;
    end
  end

  function automatic bit m_sda();
    return (m_act && m_drv) ? m_byte[m_pos] : 1'b1;
  endfunction

  task automatic check(input string t, input logic act_v, input logic exp_v, input string what);
    checks++;
    if (act_v !== exp_v) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", t, what, act_v, exp_v);
    end
  endtask

  task automatic compare_all();
    check(tag, wreq_o, m_flag, "model wreq_o");
    check(tag, sda_o, m_sda(), "model sda_o");
    check(tag, ack_o, m_ack, "model ack_o");
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cycles++;
    compare_all();
  endtask

  task automatic do_start(); start = 1; tick(); start = 0; endtask
  task automatic do_stop();  stop = 1;  tick(); stop = 0;  endtask
  task automatic do_write(input logic [DW-1:0] d); wr = 1; wd = d; tick(); wr = 0; endtask

  // nine SCL pulses; checks each presented bit and the ack-slot release
  task automatic run_byte(input logic [DW-1:0] d, input logic ackv, input bit shown);
    for (int i = 0; i <= DW; i++) begin
      fall = 1; tick(); fall = 0;
      check("R5", sda_o, (shown && i < DW) ? d[DW-1-i] : 1'b1, "serial bit");
      tick();
      if (i == DW) sda_in = ackv;
      rise = 1; tick(); rise = 0; sda_in = 1'b0;
      if (i < DW) tick();
    end
  endtask

  always @(posedge clk) begin
    if (!done_run && cycles > 5000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=5000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tag = "R1";
    repeat (2) @(negedge clk);
    check("R1", wreq_o, 1'b0, "reset wreq_o");
    check("R1", sda_o, 1'b1, "reset sda_o");
    check("R1", ack_o, 1'b0, "reset ack_o");
    rst_n = 1;
    en = 1; tx = 1;
    tick();

    tag = "R2";
    do_start();
    check("R2", wreq_o, 1'b1, "start sets flag");

    tag = "R3";
    do_write(8'hA5);
    check("R3", wreq_o, 1'b0, "write clears flag");
    tick();
    check("R3", wreq_o, 1'b1, "idle load sets flag again");

    tag = "R4";
    do_write(8'h3C);
    check("R4", wreq_o, 1'b0, "byte waiting");
    run_byte(8'hA5, 1'b0, 1);
    check("R4", wreq_o, 1'b1, "load on 9th rise");
    check("R6", ack_o, 1'b0, "ack sampled");

    tag = "R11";
    run_byte(8'h3C, 1'b1, 1);
    check("R11", wreq_o, 1'b1, "flag stays set, unchecked nack");
    check("R6", ack_o, 1'b1, "nack sampled");

    tag = "R3";
    do_write(8'h81);
    check("R3", wreq_o, 1'b0, "drop after completed transfer");
    tick();
    check("R3", wreq_o, 1'b1, "rise after completed transfer");

    tag = "R7";
    do_write(8'h42);
    chk = 1;
    run_byte(8'h81, 1'b1, 1);
    check("R7", wreq_o, 1'b0, "checked nack leaves flag clear");
    run_byte(8'h42, 1'b0, 0);
    check("R7", wreq_o, 1'b0, "no load after checked nack");

    tag = "R8";
    do_stop();
    check("R8", wreq_o, 1'b0, "stop clears flag");
    tick();
    check("R8", wreq_o, 1'b0, "no load without bus");

    tag = "R2";
    chk = 0;
    do_start();
    check("R2", wreq_o, 1'b1, "start after stop loads waiting byte");

    tag = "R10";
    tx = 0;
    do_write(8'h99);
    check("R10", wreq_o, 1'b1, "write with tx off ignored");
    tx = 1;
    run_byte(8'h42, 1'b0, 1);
    check("R10", wreq_o, 1'b1, "ignored byte not queued");

    tag = "R8";
    do_write(8'h55);
    tick();
    fall = 1; tick(); fall = 0; tick();
    rise = 1; tick(); rise = 0; tick();
    do_stop();
    check("R8", wreq_o, 1'b0, "stop mid-byte clears flag");
    check("R8", sda_o, 1'b1, "stop mid-byte releases sda");

    tag = "R9";
    do_write(8'h77);
    check("R9", wreq_o, 1'b0, "pending byte with bus idle");
    init = 1; tick(); init = 0;
    check("R9", wreq_o, 1'b0, "init clears flag");
    do_start();
    check("R9", wreq_o, 1'b1, "start after init");
    run_byte(8'h77, 1'b0, 0);
    check("R9", sda_o, 1'b1, "holding cleared by init");
    en = 0; tick();
    check("R9", wreq_o, 1'b0, "disable clears flag");
    do_start();
    check("R9", wreq_o, 1'b0, "start ignored while disabled");

    done_run = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule